// File: doc/BRIEF.md
# Dual-output IRQ/FIQ interrupt controller

A register-mapped controller that collects up to 64 level-sensitive, active-high interrupt sources and drives two request lines toward a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Every source has a mask bit and a route bit. The route bit sends it to one of the two outputs. Software reads the raw pending sources, a view filtered for each output, and the number of the winning source on each output.

Sources pass through a two-flop synchronizer and then into a raw status register. A pending bit follows its input level, so it clears when the input drops. A priority base register sets where the winner search starts. The search then goes upward and wraps past the top source. With a base of zero the lowest-numbered active source wins. The `NUM_SRC` parameter selects 32 or 64 sources. The second register bank, which serves sources 32 to 63, exists only in the 64-source build.

Top module: `dirq_ctrl`

## Requirements
- R1: After reset the enable and select registers are zero, `irq_o` and `fiq_o` are low, and both winner index registers read 0x3F.
- R2: The raw status register at 0x00 (sources 0-31) and at 0x20 (sources 32-63, bit n is source n+32) shows the input levels within three clock cycles. A bit clears once its input drops.
- R3: The enable registers at 0x04 and 0x24 are read/write. A 1 unmasks the source and a 0 masks it.
- R4: The select registers at 0x08 and 0x28 are read/write. A 0 routes the source to IRQ and a 1 routes it to FIQ. IRQ status at 0x0C/0x2C reads raw & enable & ~select. FIQ status at 0x10/0x30 reads raw & enable & select.
- R5: `irq_o` is the registered OR of all IRQ status bits in both banks. `fiq_o` is the registered OR of all FIQ status bits.
- R6: The IRQ winner register at 0x18 and the FIQ winner register at 0x1C return, in bits [5:0], the number of the winning active source on that output. They return 0x3F when that output has no active source. With a priority base of 0 the winner is the lowest-numbered active source.
- R7: The priority register at 0x14 holds a base in bits [log2(NUM_SRC)-1:0]. The search starts at the base, goes upward and wraps past NUM_SRC-1 to 0.
- R8: The raw and filtered status registers are read-only. Writes to them leave every register and output unchanged.
- R9: Unmapped addresses read zero. With NUM_SRC=32, every second-bank address reads zero and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt sources, active high |
| bus_addr_i | input | 8 | Byte address of register |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds two instances side by side. The 64-source build exercises both banks, the wrap of the rotating winner search across the bank boundary, and the case where source 63 returns the same code as "none". The 32-source build shares the same bus and inputs. It shows that the absent second bank reads zero and takes no writes, while its first bank still follows the same model.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam logic [7:0] A_RAW  = 8'h00;
  localparam logic [7:0] A_ENA  = 8'h04;
  localparam logic [7:0] A_SEL  = 8'h08;
  localparam logic [7:0] A_IST  = 8'h0C;
  localparam logic [7:0] A_FST  = 8'h10;
  localparam logic [7:0] A_PRI  = 8'h14;
  localparam logic [7:0] A_IWIN = 8'h18;
  localparam logic [7:0] A_FWIN = 8'h1C;
  localparam logic [7:0] A_RAW2 = 8'h20;
  localparam logic [7:0] A_ENA2 = 8'h24;
  localparam logic [7:0] A_SEL2 = 8'h28;
  localparam logic [7:0] A_IST2 = 8'h2C;
  localparam logic [7:0] A_FST2 = 8'h30;
  localparam logic [5:0] IDX_NONE = 6'h3F;
endpackage

// File: rtl/dirq_sync.sv
module dirq_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dirq_pick.sv
module dirq_pick
  import dirq_pkg::*;
#(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] base_i,
  output logic [5:0]    idx_o
);
  logic [IW-1:0] pos;
  logic          hit;

  // rotating search: N is a power of two, so the index wraps by truncation
  always_comb begin
    idx_o = IDX_NONE;
    hit   = 1'b0;
    pos   = '0;
    for (int i = 0; i < N; i++) begin
      pos = base_i + IW'(i);
      if (!hit && vec_i[pos]) begin
        hit   = 1'b1;
        idx_o = 6'(pos);
      end
    end
  end

  a_r6_none_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_i == '0) |-> (idx_o == IDX_NONE));
  a_r6_winner_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_i != '0) |-> vec_i[idx_o[IW-1:0]]);
  a_r7_base_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_i[base_i] |-> (idx_o[IW-1:0] == base_i));
endmodule

// File: rtl/dirq_ctrl.sv
module dirq_ctrl
  import dirq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [7:0]         bus_addr_i,
  input  logic               bus_we_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam bit  HAS_HI  = (NUM_SRC > 32);
  localparam int  IW      = $clog2(NUM_SRC);
  localparam logic [31:0] HI_MASK = HAS_HI ? 32'hFFFF_FFFF : 32'h0;

  logic [NUM_SRC-1:0] src_s;
  logic [63:0]        src_ext, raw_q, en_q, sel_q, irq_stat, fiq_stat;
  logic [IW-1:0]      pri_q;
  logic [5:0]         irq_win, fiq_win;

  dirq_sync #(.W(NUM_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i), .q_o(src_s)
  );

  generate
    if (HAS_HI) begin : g_wide
      assign src_ext = src_s;
    end else begin : g_narrow
      assign src_ext = {32'h0, src_s};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
      sel_q <= '0;
      pri_q <= '0;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      raw_q <= src_ext;
      irq_o <= |irq_stat;
      fiq_o <= |fiq_stat;
      if (bus_we_i) begin
        case (bus_addr_i)
          A_ENA:   en_q[31:0]   <= bus_wdata_i;
          A_SEL:   sel_q[31:0]  <= bus_wdata_i;
          A_ENA2:  en_q[63:32]  <= bus_wdata_i & HI_MASK;
          A_SEL2:  sel_q[63:32] <= bus_wdata_i & HI_MASK;
          A_PRI:   pri_q        <= bus_wdata_i[IW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_stat = raw_q & en_q & ~sel_q;
  assign fiq_stat = raw_q & en_q & sel_q;

  dirq_pick #(.N(NUM_SRC)) u_pick_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .vec_i(irq_stat[NUM_SRC-1:0]),
    .base_i(pri_q), .idx_o(irq_win)
  );
  dirq_pick #(.N(NUM_SRC)) u_pick_fiq (
    .clk_i(clk_i), .rst_ni(rst_ni), .vec_i(fiq_stat[NUM_SRC-1:0]),
    .base_i(pri_q), .idx_o(fiq_win)
  );

  // upper halves stay zero in the 32-source build, so bank 2 reads zero
  always_comb begin
    case (bus_addr_i)
      A_RAW:   bus_rdata_o = raw_q[31:0];
      A_ENA:   bus_rdata_o = en_q[31:0];
      A_SEL:   bus_rdata_o = sel_q[31:0];
      A_IST:   bus_rdata_o = irq_stat[31:0];
      A_FST:   bus_rdata_o = fiq_stat[31:0];
      A_PRI:   bus_rdata_o = 32'(pri_q);
      A_IWIN:  bus_rdata_o = 32'(irq_win);
      A_FWIN:  bus_rdata_o = 32'(fiq_win);
      A_RAW2:  bus_rdata_o = raw_q[63:32];
      A_ENA2:  bus_rdata_o = en_q[63:32];
      A_SEL2:  bus_rdata_o = sel_q[63:32];
      A_IST2:  bus_rdata_o = irq_stat[63:32];
      A_FST2:  bus_rdata_o = fiq_stat[63:32];
      default: bus_rdata_o = 32'h0;
    endcase
  end

  a_r4_routes_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat & fiq_stat) == 64'h0);
  a_r5_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_stat) |=> irq_o);
  a_r5_fiq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fiq_stat) |=> fiq_o);
  a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_q & en_q) == 64'h0) |=> (!irq_o && !fiq_o));
  a_r8_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && (bus_addr_i == A_IST || bus_addr_i == A_RAW)) |=>
      ($stable(en_q) && $stable(sel_q) && $stable(pri_q)));
endmodule

// File: tb/dirq_ctrl_tb.sv
`timescale 1ns/1ps
module dirq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic        irq, fiq, irq_s, fiq_s;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [63:0] m_en = '0, m_sel = '0;
  int          m_pri = 0;

  always #4 clk = ~clk;

  dirq_ctrl #(.NUM_SRC(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );
  dirq_ctrl #(.NUM_SRC(32)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src[31:0]), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata_s),
    .irq_o(irq_s), .fiq_o(fiq_s)
  );

  function automatic logic [5:0] pick(logic [63:0] v, int n, int base);
    for (int i = 0; i < n; i++) begin
      int p = (base + i) % n;
      if (v[p]) return 6'(p);
    end
    return 6'h3F;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata; ds = rdata_s;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d, ds;
    logic [63:0] ist, fst;
    ist = src & m_en & ~m_sel;
    fst = src & m_en & m_sel;
    rd(8'h00, d, ds); chk({"R2 raw lo ", tag}, d, src[31:0]);
    chk({"R2 raw small ", tag}, ds, src[31:0]);
    rd(8'h20, d, ds); chk({"R2 raw hi ", tag}, d, src[63:32]);
    chk({"R9 small raw hi ", tag}, ds, 0);
    rd(8'h04, d, ds); chk({"R3 en lo ", tag}, d, m_en[31:0]);
    rd(8'h24, d, ds); chk({"R3 en hi ", tag}, d, m_en[63:32]);
    chk({"R9 small en hi ", tag}, ds, 0);
    rd(8'h0C, d, ds); chk({"R4 irq st lo ", tag}, d, ist[31:0]);
    chk({"R4 small irq st ", tag}, ds, ist[31:0]);
    rd(8'h2C, d, ds); chk({"R4 irq st hi ", tag}, d, ist[63:32]);
    rd(8'h10, d, ds); chk({"R4 fiq st lo ", tag}, d, fst[31:0]);
    rd(8'h30, d, ds); chk({"R4 fiq st hi ", tag}, d, fst[63:32]);
    chk({"R9 small fiq hi ", tag}, ds, 0);
    rd(8'h18, d, ds); chk({"R6 R7 irq win ", tag}, d, pick(ist, 64, m_pri));
    chk({"R7 small irq win ", tag}, ds, pick(ist & 64'hFFFF_FFFF, 32, m_pri % 32));
    rd(8'h1C, d, ds); chk({"R6 R7 fiq win ", tag}, d, pick(fst, 64, m_pri));
    chk({"R5 irq_o ", tag}, irq, |ist);
    chk({"R5 fiq_o ", tag}, fiq, |fst);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, ds;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h04, d, ds); chk("R1 en reset", d, 0);
    rd(8'h08, d, ds); chk("R1 sel reset", d, 0);
    rd(8'h18, d, ds); chk("R1 irq win reset", d, 32'h3F);
    rd(8'h1C, d, ds); chk("R1 fiq win reset", d, 32'h3F);
    chk("R1 irq_o reset", irq, 0);
    chk("R1 fiq_o reset", fiq, 0);

    // R2 level follow and clear, masked sources stay quiet (R3)
    src = 64'h8000_0001_0000_0010; settle();
    check_all("masked");
    src = '0; settle();
    check_all("dropped");

    // R3 R4 directed routing across banks
    m_en = 64'hFFFF_FFFF_FFFF_FFFF; wr(8'h04, m_en[31:0]); wr(8'h24, m_en[63:32]);
    m_sel = 64'h0000_0004_0000_0100; wr(8'h08, m_sel[31:0]); wr(8'h28, m_sel[63:32]);
    src = 64'h0000_0024_0000_0120; settle();
    check_all("route");

    // R7 wrap across the top source
    m_pri = 40; wr(8'h14, 32'd40);
    src = 64'h0000_0001_0000_0100; settle();
    check_all("wrap");
    src = 64'h8000_0000_0000_0000; settle();
    check_all("src63");
    m_pri = 0; wr(8'h14, 0);

    // R8 writes to read-only status registers
    src = 64'h0000_0010_0000_0001; settle();
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h0C, 32'h0); wr(8'h10, 32'hFFFF);
    wr(8'h2C, 32'h0); wr(8'h30, 32'hFFFF_FFFF); wr(8'h20, 32'h0);
    wr(8'h18, 32'h5); wr(8'h1C, 32'h5);
    settle();
    check_all("R8 ro");

    // R9 unmapped addresses
    rd(8'h34, d, ds); chk("R9 unmapped 0x34", d, 0);
    rd(8'h40, d, ds); chk("R9 unmapped 0x40", d, 0);
    rd(8'hFC, d, ds); chk("R9 unmapped small", ds, 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      src = (it % 2 == 0) ? r : (r & {$urandom(), $urandom()} & {$urandom(), $urandom()});
      if (it % 3 == 0) begin
        m_en = {$urandom(), $urandom()};
        wr(8'h04, m_en[31:0]); wr(8'h24, m_en[63:32]);
      end
      if (it % 4 == 1) begin
        m_sel = {$urandom(), $urandom()};
        wr(8'h08, m_sel[31:0]); wr(8'h28, m_sel[63:32]);
      end
      if (it % 5 == 2) begin
        m_pri = int'($urandom() % 64);
        wr(8'h14, 32'(m_pri));
      end
      settle();
      check_all("random");
    end

    // disable all, route all to IRQ
    m_en = '0; m_sel = '0;
    wr(8'h04, 0); wr(8'h24, 0); wr(8'h08, 0); wr(8'h28, 0);
    settle();
    check_all("R3 all off");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule